// File: doc/BRIEF.md
# Dual-Slot Instruction Word Dispatcher

The dispatcher takes one 32-bit instruction word at a time and turns it into one or two sub-instructions for a downstream execute stage. It hands them over one per cycle on a valid/ready handshake. The two top bits of the word choose the form:

- a single long instruction;
- two short instructions issued in sequence, in either order;
- two short instructions paired for parallel execution.

In the parallel form, one slot may belong to a condition-only class. That slot is issued first. Its partner then waits until the execute stage returns a flag strobe. The partner is issued when the flag is true and dropped when it is false.

Every issued item carries its opcode bits, a slot tag and a 6-bit class index. A new word is taken only after the previous one has been fully issued or dropped. A one-cycle done pulse closes each word.

Top module: `slot_dispatch`

## Requirements
- R1: After reset, word_ready_o is 1, iss_valid_o is 0 and done_o is 0.
- R2: Format bits word[31:30]=11 issue exactly one item. Its tag is 4 (long), its bits are word[29:0] and its class is word[29:24].
- R3: Format 10 issues the right slot word[14:0] first with tag 1 (right), then the left slot word[29:15] with tag 0 (left).
- R4: Format 01 issues the left slot first with tag 0, then the right slot with tag 1.
- R5: Format 00 with neither slot condition-only issues the left slot with tag 2 (left-parallel), then the right slot with tag 3 (right-parallel).
- R6: A short item carries its 15-bit slot in iss_bits_o[14:0] with bits 29:15 zero, and its class equals slot bits 14:9.
- R7: A slot is condition-only when its bits 14:9 equal 60 or 61. These are the default mask/match pairs 0x7E00/0x7800 and 0x7E00/0x7A00. The classification applies only in format 00.
- R8: In format 00 with a condition-only left slot, the left slot issues first with tag 0. The dispatcher then waits for flag_valid_i. If flag_i is 1, the right slot issues with tag 1. If flag_i is 0, nothing more issues and the word completes. The left slot wins when both slots are condition-only.
- R9: In format 00 where only the right slot is condition-only, the right slot issues first with tag 1. The left slot then follows with tag 0 only on a true flag.
- R10: flag_valid_i has no effect outside the wait for a condition flag. A false flag strobe during a sequential or unconditional pair drops nothing.
- R11: word_ready_o is 0 while a word is in progress. done_o is a one-cycle pulse in the cycle after the last handshake or the drop, with word_ready_o back at 1.
- R12: While iss_valid_o is 1 and iss_ready_i is 0, the issued item stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_valid_i | input | 1 | Instruction word offered |
| word_i | input | 32 | Instruction word |
| word_ready_o | output | 1 | Dispatcher can take a word |
| iss_valid_o | output | 1 | Sub-instruction offered downstream |
| iss_ready_i | input | 1 | Execute stage takes the sub-instruction |
| iss_bits_o | output | 30 | Opcode bits (short slots zero-extended) |
| iss_tag_o | output | 3 | Slot tag: 0 left, 1 right, 2 left-parallel, 3 right-parallel, 4 long |
| iss_class_o | output | 6 | Opcode class index |
| flag_valid_i | input | 1 | Condition flag strobe from execute |
| flag_i | input | 1 | Condition flag value |
| done_o | output | 1 | Word completed pulse |

## Verification
The hardest situation to reach from the ports is the conditional wait. The bench has to prove two things about it: the partner slot is held back for as long as no flag strobe arrives, and a strobe arriving at any other time changes nothing. To reach it, the bench sends condition-only parallel words and holds the flag strobe low for several idle cycles after the first item. It checks that nothing issues in that gap, and only then pulses the flag with either value. Separate runs keep a false strobe asserted throughout sequential pairs, and others stall the consumer to freeze the first item.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int WORD_W  = 32;
  localparam int LONG_W  = 30;
  localparam int SHORT_W = 15;
  localparam int CLASS_W = 6;

  typedef enum logic [2:0] {
    TAG_LEFT  = 3'd0,
    TAG_RIGHT = 3'd1,
    TAG_LPAR  = 3'd2,
    TAG_RPAR  = 3'd3,
    TAG_LONG  = 3'd4
  } slot_tag_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_WAIT,
    ST_SECOND
  } disp_state_e;

  typedef struct packed {
    logic [LONG_W-1:0]  bits;
    slot_tag_e          tag;
    logic [CLASS_W-1:0] cls;
  } issue_item_t;

  typedef struct packed {
    issue_item_t first;
    issue_item_t second;
    logic        has_second;
    logic        cond;
  } word_plan_t;
endpackage

// File: rtl/disp_cond_match.sv
module disp_cond_match #(
  parameter int N_PAT = 2,
  parameter int SW    = 15,
  parameter logic [N_PAT*SW-1:0] PAT_MASK  = '0,
  parameter logic [N_PAT*SW-1:0] PAT_MATCH = '0
) (
  input  logic [SW-1:0] slot_i,
  output logic          hit_o
);
  logic [N_PAT-1:0] hits;

  for (genvar g = 0; g < N_PAT; g++) begin : g_pat
    assign hits[g] = (slot_i & PAT_MASK[g*SW +: SW]) == PAT_MATCH[g*SW +: SW];
  end

  assign hit_o = |hits;
endmodule

// File: rtl/disp_word_decode.sv
module disp_word_decode
  import disp_pkg::*;
#(
  parameter int N_PAT = 2,
  parameter logic [N_PAT*SHORT_W-1:0] PAT_MASK  = '0,
  parameter logic [N_PAT*SHORT_W-1:0] PAT_MATCH = '0
) (
  input  logic [WORD_W-1:0] word_i,
  output word_plan_t        plan_o
);
  localparam int CLS_LO = SHORT_W - CLASS_W;

  logic [SHORT_W-1:0] lslot, rslot;
  logic               lcond, rcond;

  assign lslot = word_i[2*SHORT_W-1:SHORT_W];
  assign rslot = word_i[SHORT_W-1:0];

  disp_cond_match #(.N_PAT(N_PAT), .SW(SHORT_W), .PAT_MASK(PAT_MASK), .PAT_MATCH(PAT_MATCH))
    u_lmatch (.slot_i(lslot), .hit_o(lcond));
  disp_cond_match #(.N_PAT(N_PAT), .SW(SHORT_W), .PAT_MASK(PAT_MASK), .PAT_MATCH(PAT_MATCH))
    u_rmatch (.slot_i(rslot), .hit_o(rcond));

  function automatic issue_item_t mk_short(input logic [SHORT_W-1:0] s, input slot_tag_e t);
    issue_item_t it;
    it.bits = {{(LONG_W-SHORT_W){1'b0}}, s};
    it.tag  = t;
    it.cls  = s[SHORT_W-1:CLS_LO];
    return it;
  endfunction

  always_comb begin
    plan_o            = '0;
    plan_o.has_second = 1'b1;
    unique case (word_i[WORD_W-1:WORD_W-2])
      2'b11: begin
        plan_o.first.bits = word_i[LONG_W-1:0];
        plan_o.first.tag  = TAG_LONG;
        plan_o.first.cls  = word_i[LONG_W-1:LONG_W-CLASS_W];
        plan_o.has_second = 1'b0;
      end
      2'b10: begin
        plan_o.first  = mk_short(rslot, TAG_RIGHT);
        plan_o.second = mk_short(lslot, TAG_LEFT);
      end
      2'b01: begin
        plan_o.first  = mk_short(lslot, TAG_LEFT);
        plan_o.second = mk_short(rslot, TAG_RIGHT);
      end
      default: begin
        if (lcond) begin
          plan_o.first  = mk_short(lslot, TAG_LEFT);
          plan_o.second = mk_short(rslot, TAG_RIGHT);
          plan_o.cond   = 1'b1;
        end else if (rcond) begin
          plan_o.first  = mk_short(rslot, TAG_RIGHT);
          plan_o.second = mk_short(lslot, TAG_LEFT);
          plan_o.cond   = 1'b1;
        end else begin
          plan_o.first  = mk_short(lslot, TAG_LPAR);
          plan_o.second = mk_short(rslot, TAG_RPAR);
        end
      end
    endcase
  end
endmodule

// File: rtl/disp_issue_fsm.sv
module disp_issue_fsm
  import disp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        word_valid_i,
  input  word_plan_t  plan_i,
  output logic        word_ready_o,
  output logic        iss_valid_o,
  input  logic        iss_ready_i,
  output issue_item_t item_o,
  input  logic        flag_valid_i,
  input  logic        flag_i,
  output logic        done_o
);
  disp_state_e state_q, state_d;
  word_plan_t  plan_q;
  logic        done_q, fin;

  assign word_ready_o = (state_q == ST_IDLE);
  assign iss_valid_o  = (state_q == ST_FIRST) || (state_q == ST_SECOND);
  assign item_o       = (state_q == ST_SECOND) ? plan_q.second : plan_q.first;
  assign done_o       = done_q;

  always_comb begin
    state_d = state_q;
    fin     = 1'b0;
    unique case (state_q)
      ST_IDLE:
        if (word_valid_i) state_d = ST_FIRST;
      ST_FIRST:
        if (iss_ready_i) begin
          if (!plan_q.has_second) begin
            state_d = ST_IDLE;
            fin     = 1'b1;
          end else if (plan_q.cond) begin
            state_d = ST_WAIT;
          end else begin
            state_d = ST_SECOND;
          end
        end
      ST_WAIT:
        if (flag_valid_i) begin
          if (flag_i) begin
            state_d = ST_SECOND;
          end else begin
            state_d = ST_IDLE;
            fin     = 1'b1;
          end
        end
      default:
        if (iss_ready_i) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
        end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      plan_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (state_q == ST_IDLE && word_valid_i) plan_q <= plan_i;
    end
  end
endmodule

// File: rtl/slot_dispatch.sv
module slot_dispatch
  import disp_pkg::*;
#(
  parameter int N_PAT = 2,
  parameter logic [N_PAT*SHORT_W-1:0] PAT_MASK  = {15'h7E00, 15'h7E00},
  parameter logic [N_PAT*SHORT_W-1:0] PAT_MATCH = {15'h7A00, 15'h7800}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_valid_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic               word_ready_o,
  output logic               iss_valid_o,
  input  logic               iss_ready_i,
  output logic [LONG_W-1:0]  iss_bits_o,
  output logic [2:0]         iss_tag_o,
  output logic [CLASS_W-1:0] iss_class_o,
  input  logic               flag_valid_i,
  input  logic               flag_i,
  output logic               done_o
);
  word_plan_t  plan;
  issue_item_t item;

  disp_word_decode #(.N_PAT(N_PAT), .PAT_MASK(PAT_MASK), .PAT_MATCH(PAT_MATCH)) u_dec (
    .word_i (word_i),
    .plan_o (plan)
  );

  disp_issue_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_i (word_valid_i),
    .plan_i       (plan),
    .word_ready_o (word_ready_o),
    .iss_valid_o  (iss_valid_o),
    .iss_ready_i  (iss_ready_i),
    .item_o       (item),
    .flag_valid_i (flag_valid_i),
    .flag_i       (flag_i),
    .done_o       (done_o)
  );

  assign iss_bits_o  = item.bits;
  assign iss_tag_o   = item.tag;
  assign iss_class_o = item.cls;
endmodule

// File: rtl/slot_dispatch_chk.sv
module slot_dispatch_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        word_ready_o,
  input logic        iss_valid_o,
  input logic        iss_ready_i,
  input logic [29:0] iss_bits_o,
  input logic [2:0]  iss_tag_o,
  input logic [5:0]  iss_class_o,
  input logic        done_o
);
  assert_ready_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_ready_o && iss_valid_o));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && !iss_ready_i) |=> (iss_valid_o && $stable(iss_bits_o) && $stable(iss_tag_o)
                                       && $stable(iss_class_o)));

  assert_long_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_ready_i && iss_tag_o == 3'd4) |=> (done_o && word_ready_o));

  assert_long_class_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_tag_o == 3'd4) |-> iss_class_o == iss_bits_o[29:24]);

  assert_short_fmt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_tag_o != 3'd4) |-> (iss_bits_o[29:15] == '0 && iss_class_o == iss_bits_o[14:9]));

  assert_par_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_ready_i && iss_tag_o == 3'd2) |=> (iss_valid_o && iss_tag_o == 3'd3));
endmodule

bind slot_dispatch slot_dispatch_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_ready_o (word_ready_o),
  .iss_valid_o  (iss_valid_o),
  .iss_ready_i  (iss_ready_i),
  .iss_bits_o   (iss_bits_o),
  .iss_tag_o    (iss_tag_o),
  .iss_class_o  (iss_class_o),
  .done_o       (done_o)
);

// File: tb/slot_dispatch_test.sv
`timescale 1ns/1ps
module slot_dispatch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word = '0;
  logic        word_ready;
  logic        iss_valid;
  logic        iss_ready = 1'b0;
  logic [29:0] iss_bits;
  logic [2:0]  iss_tag;
  logic [5:0]  iss_class;
  logic        flag_valid = 1'b0;
  logic        flag_v = 1'b0;
  logic        done;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  slot_dispatch uut (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(word_valid), .word_i(word),
    .word_ready_o(word_ready), .iss_valid_o(iss_valid), .iss_ready_i(iss_ready),
    .iss_bits_o(iss_bits), .iss_tag_o(iss_tag), .iss_class_o(iss_class),
    .flag_valid_i(flag_valid), .flag_i(flag_v), .done_o(done)
  );

  // {flag, word}
  localparam int NV = 11;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 32'hEA12_3456},  // R2 long
    {1'b0, 32'h891A_0ABC},  // R3 right then left, false flag held (R10)
    {1'b0, 32'h491A_0ABC},  // R4 left then right, false flag held (R10)
    {1'b0, 32'h091A_0ABC},  // R5 parallel, no cond
    {1'b1, 32'h3C2A_8ABC},  // R8 left cond, flag true
    {1'b0, 32'h3C2A_8ABC},  // R8 left cond, flag false
    {1'b1, 32'h091A_7A11},  // R9 right cond, flag true
    {1'b0, 32'h091A_7A11},  // R9 right cond, flag false
    {1'b1, 32'h3C2A_FA11},  // R8 both cond, left wins
    {1'b0, 32'hBC2A_FA11},  // R7 cond slots in sequential form ignored
    {1'b0, 32'hFFFF_FFFF}   // R2 long class 63
  };

  function automatic logic is_cond(input logic [14:0] s);
    return s[14:9] == 6'd60 || s[14:9] == 6'd61;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] w, input logic f, output int n,
                       output logic [29:0] b0, output logic [2:0] t0,
                       output logic [29:0] b1, output logic [2:0] t1);
    logic [14:0] l, r;
    l = w[29:15];
    r = w[14:0];
    b1 = '0; t1 = '0;
    case (w[31:30])
      2'b11: begin n = 1; b0 = w[29:0]; t0 = 3'd4; end
      2'b10: begin n = 2; b0 = {15'b0, r}; t0 = 3'd1; b1 = {15'b0, l}; t1 = 3'd0; end
      2'b01: begin n = 2; b0 = {15'b0, l}; t0 = 3'd0; b1 = {15'b0, r}; t1 = 3'd1; end
      default: begin
        if (is_cond(l)) begin
          n = f ? 2 : 1; b0 = {15'b0, l}; t0 = 3'd0; b1 = {15'b0, r}; t1 = 3'd1;
        end else if (is_cond(r)) begin
          n = f ? 2 : 1; b0 = {15'b0, r}; t0 = 3'd1; b1 = {15'b0, l}; t1 = 3'd0;
        end else begin
          n = 2; b0 = {15'b0, l}; t0 = 3'd2; b1 = {15'b0, r}; t1 = 3'd3;
        end
      end
    endcase
  endtask

  task automatic run_word(input logic [31:0] w, input logic f, input int stall,
                          input bit flag_always, input string req);
    int          n_exp, ngot, gap, stall_left;
    logic [29:0] eb0, eb1, sb;
    logic [2:0]  et0, et1, st;
    logic [5:0]  sc;
    logic [29:0] gb [4];
    logic [2:0]  gt [4];
    logic [5:0]  gc [4];
    bit          done_seen, busy_bad, hold_bad, flag_sent, early;
    model(w, f, n_exp, eb0, et0, eb1, et1);
    @(negedge clk);
    chk(word_ready == 1'b1, {req, " R11 ready before word"}, {31'b0, word_ready}, 32'd1);
    word_valid = 1'b1; word = w; iss_ready = 1'b0;
    flag_valid = flag_always; flag_v = f;
    @(negedge clk);
    word_valid = 1'b0;
    ngot = 0; gap = 0; stall_left = stall;
    done_seen = 0; busy_bad = 0; hold_bad = 0; flag_sent = 0; early = 0;
    sb = '0; st = '0; sc = '0;
    for (int cyc = 0; cyc < 40 && !done_seen; cyc++) begin
      if (done) begin
        done_seen = 1;
      end else begin
        if (word_ready) busy_bad = 1;
        if (!flag_always) flag_valid = 1'b0;
        if (iss_valid) begin
          if (stall_left > 0) begin
            if (stall_left == stall) begin
              sb = iss_bits; st = iss_tag; sc = iss_class;
            end else if (iss_bits != sb || iss_tag != st || iss_class != sc) begin
              hold_bad = 1;
            end
            stall_left--;
            iss_ready = 1'b0;
          end else begin
            if (ngot < 4) begin
              gb[ngot] = iss_bits; gt[ngot] = iss_tag; gc[ngot] = iss_class;
            end
            if (ngot == 1 && !flag_always && !flag_sent) early = 1;
            ngot++;
            iss_ready = 1'b1;
          end
        end else begin
          iss_ready = 1'b0;
          if (ngot > 0) gap++;
          if (!flag_always && gap == 3) begin
            flag_valid = 1'b1; flag_sent = 1;
          end
        end
        @(negedge clk);
      end
    end
    iss_ready = 1'b0; flag_valid = 1'b0;
    chk(done_seen, {req, " R11 done pulse"}, {31'b0, done_seen}, 32'd1);
    chk(!busy_bad, {req, " R11 ready low while busy"}, {31'b0, busy_bad}, 32'd0);
    chk(word_ready, {req, " R11 ready with done"}, {31'b0, word_ready}, 32'd1);
    chk(ngot == n_exp, {req, " item count"}, ngot, n_exp);
    if (stall > 0) chk(!hold_bad, {req, " R12 held while stalled"}, {31'b0, hold_bad}, 32'd0);
    if (!flag_always) chk(!early, {req, " R8 partner held until flag"}, {31'b0, early}, 32'd0);
    if (ngot >= 1) begin
      chk(gb[0] == eb0, {req, " first bits"}, {2'b0, gb[0]}, {2'b0, eb0});
      chk(gt[0] == et0, {req, " first tag"}, {29'b0, gt[0]}, {29'b0, et0});
      chk(gc[0] == (et0 == 3'd4 ? eb0[29:24] : eb0[14:9]), {req, " R6 first class"},
          {26'b0, gc[0]}, {26'b0, (et0 == 3'd4 ? eb0[29:24] : eb0[14:9])});
    end
    if (ngot >= 2 && n_exp >= 2) begin
      chk(gb[1] == eb1, {req, " second bits"}, {2'b0, gb[1]}, {2'b0, eb1});
      chk(gt[1] == et1, {req, " second tag"}, {29'b0, gt[1]}, {29'b0, et1});
      chk(gc[1] == eb1[14:9], {req, " R6 second class"}, {26'b0, gc[1]}, {26'b0, eb1[14:9]});
    end
    @(negedge clk);
    chk(!done, {req, " R11 done one cycle"}, {31'b0, done}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(word_ready == 1'b1, "R1 ready in reset", {31'b0, word_ready}, 32'd1);
    chk(iss_valid == 1'b0, "R1 no issue in reset", {31'b0, iss_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word_ready == 1'b1 && iss_valid == 1'b0 && done == 1'b0, "R1 state after reset",
        {29'b0, word_ready, iss_valid, done}, 32'd4);

    for (int i = 0; i < NV; i++)
      run_word(VEC[i][31:0], VEC[i][32], 0, 1'b1, $sformatf("vec%0d", i));

    // R12 consumer stall on each form
    run_word(32'h491A_0ABC, 1'b0, 3, 1'b1, "R12 seq stall");
    run_word(32'hEA12_3456, 1'b0, 4, 1'b1, "R12 long stall");
    // R8 / R9 delayed flag strobe
    run_word(32'h3C2A_8ABC, 1'b1, 0, 1'b0, "R8 late flag true");
    run_word(32'h3C2A_8ABC, 1'b0, 0, 1'b0, "R8 late flag false");
    run_word(32'h091A_7A11, 1'b1, 2, 1'b0, "R9 late flag stall");
    // R10 false strobe through a parallel unconditional pair
    run_word(32'h091A_0ABC, 1'b0, 2, 1'b1, "R10 parallel");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule